// File: doc/BRIEF.md
# Serial-Bus Real-Time Clock with Scratch SRAM

This block is a slave on a chip-select-framed, bit-serial bus. It keeps a seconds counter driven by a clock prescaler, a small battery-backed scratch memory, a counter snapshot, two power timer set values, four trim registers and two control registers. One of the control registers gathers sticky power-event flags that power-management logic raises through dedicated event inputs.

A host lowers `cs_n` and shifts a 32-bit command word into `din`, most significant bit first, one bit per `bit_vld` strobe. Bit 31 of the command selects a write; bits 30..0 are the register offset. A second 32-bit word follows. For a write it is shifted in and committed on its final strobe. For a read the device returns the addressed register on `dout`. Raising `cs_n` ends or aborts the frame at any point.

Top module: `rtc_serial_dev`

## Requirements
- R1: A frame is a 32-bit command word followed by a 32-bit data word, both MSB first, one bit per `bit_vld` cycle while `cs_n` is low. Command bit 31 set means write: the data word is stored on its last strobe. Bit 31 clear means read: `dout` shows bit 31 of the addressed register from the cycle after the command's last strobe and moves to the next lower bit after each data strobe.
- R2: The counter at offset 0x20000000 increments once every TICK_DIV clock cycles. A write loads the value and restarts the prescaler, so the next increment comes TICK_DIV cycles after the write.
- R3: Sixteen scratch words decode at 0x20000100 + 0x100*i (i = 0..15) and are readable and writable.
- R4: The snapshot register at 0x20400000 copies the counter in any cycle where event input bit 3 (ON-timer power-on) or bit 4 (system power event) is high. It resets to zero, and writes to it are ignored.
- R5: The ON timer set register (0x21000000) and the OFF timer set register (0x21000100) are 32-bit read/write registers that reset to zero.
- R6: Four trim registers at 0x21000400, 0x21000500, 0x21000600 and 0x21000700 reset to 0x03030303 and are read/write.
- R7: Control register 0 at 0x21000C00 reads its bits 7..0 as the REV parameter, and writes never change them. Event input bit k sets a sticky flag at a fixed position: bit 0 to bit 8 (canary), bit 1 to bit 9 (low battery), bit 2 to bit 11 (unstable power), bit 3 to bit 16 (ON-timer power-on), bit 4 to bit 17 (system power event), bit 5 to bit 24 (OFF-timer power-off), bit 6 to bit 25 (long button press), and bit 7 to bit 26 (forced power-off). All other bits read zero.
- R8: Writing 1 to a flag position of control register 0 clears that flag, and writing 0 leaves it as it is. An event that arrives in the same cycle as the clear keeps the flag set.
- R9: Control register 1 at 0x21000D00 is a 32-bit read/write register that resets to zero.
- R10: A read of an undecoded offset returns zero. A write to an undecoded offset changes no register.
- R11: If `cs_n` rises before the data word is complete, no register changes. The next frame starts again with a fresh command word.
- R12: After reset the counter, snapshot, timer sets, control register 1 and all flags are zero, and control register 0 reads as REV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the prescaler source |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| bit_vld | input | 1 | One-cycle strobe marking a serial bit |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial read data to host |
| evt | input | 8 | Power-event inputs that set the sticky flags |

## Verification
The assertions check the following on every cycle: the counter holds, increments or loads exactly as the prescaler tick and load strobe dictate; flags stay set until cleared and always set after an event; the snapshot holds unless a power-on event occurs; deselection returns the frame logic to an idle command phase; and a write to an undecoded offset leaves the plain registers unchanged. Only the bench scenarios can show the offset map, the serial bit order seen at `dout`, the reset values, the write-one-to-clear encoding, the event-beats-clear race and prescaler restart on a counter load. Aborted frames are also covered only there, and each of these needs a full transaction and a read back through the bus.

// File: rtl/rtc_pkg.sv
// Package: shared offsets, flag layout and types for the serial RTC.
// Assumes 32-bit command and data words; offsets exclude the write flag.
package rtc_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_FLAGS = 8;
    localparam int unsigned NUM_TRIM  = 4;

    localparam logic [31:0] OFF_COUNT = 32'h2000_0000;
    localparam logic [31:0] OFF_SRAM  = 32'h2000_0100;
    localparam logic [31:0] OFF_SNAP  = 32'h2040_0000;
    localparam logic [31:0] OFF_ONT   = 32'h2100_0000;
    localparam logic [31:0] OFF_OFFT  = 32'h2100_0100;
    localparam logic [31:0] OFF_TRIM  = 32'h2100_0400;
    localparam logic [31:0] OFF_CTL0  = 32'h2100_0C00;
    localparam logic [31:0] OFF_CTL1  = 32'h2100_0D00;

    localparam logic [31:0] TRIM_INIT = 32'h0303_0303;

    // Event input indices that count as a power-on for the snapshot.
    localparam int unsigned EV_PON_TMR = 3;
    localparam int unsigned EV_PON_SYS = 4;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DATA,
        PH_DONE
    } phase_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_SRAM,
        SEL_SNAP,
        SEL_ONT,
        SEL_OFFT,
        SEL_TRIM,
        SEL_CTL0,
        SEL_CTL1
    } sel_e;

    typedef struct packed {
        sel_e       kind;
        logic [7:0] idx;
    } dec_t;

    // Bit position in control register 0 for event input k.
    function automatic int unsigned flag_bit(input int unsigned k);
        case (k)
            0:       return 8;
            1:       return 9;
            2:       return 11;
            3:       return 16;
            4:       return 17;
            5:       return 24;
            6:       return 25;
            default: return 26;
        endcase
    endfunction

endpackage

// File: rtl/rtc_seconds.sv
// Seconds counter: a prescaler divides clk by TICK_DIV; each wrap advances
// the count. A load sets the count and restarts the prescaler.
// Assumes TICK_DIV >= 2.
module rtc_seconds #(
    parameter int unsigned TICK_DIV = 100_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    output logic [31:0] count
);
    localparam int unsigned PW   = $clog2(TICK_DIV);
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] presc_q;
    logic          tick;

    assign tick = (presc_q == LAST);

    // Prescaler: counts clk cycles within one second, restarts on load.
    always_ff @(posedge clk) begin
        if (!rst_n)             presc_q <= '0;
        else if (load || tick)  presc_q <= '0;
        else                    presc_q <= presc_q + 1'b1;
    end

    // Seconds value: load has priority over the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (tick)  count <= count + 32'd1;
    end

    a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (count == $past(count) + 32'd1));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (presc_q == '0));

endmodule

// File: rtl/rtc_serial_if.sv
// Serial frame engine: shifts in a command word and a data word MSB first,
// fetches read data at the end of the command and shifts it out, and issues
// a one-cycle write strobe on the last data bit of a write frame.
// Assumes bit_vld is a single-cycle strobe in the clk domain.
module rtc_serial_if
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        bit_vld,
    input  logic        din,
    output logic        dout,
    output logic [31:0] rd_addr,
    input  logic [31:0] rd_data,
    output logic        wr_en,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data
);
    logic [30:0] sh_q;
    logic [31:0] sh_nxt;
    logic [31:0] out_q;
    logic [31:0] cmd_q;
    logic [4:0]  cnt_q;
    phase_e      ph_q;
    logic        last;
    logic        act;

    assign sh_nxt  = {sh_q, din};
    assign last    = (cnt_q == 5'd31);
    assign act     = !cs_n && bit_vld;
    assign rd_addr = {1'b0, sh_nxt[30:0]};
    assign wr_addr = {1'b0, cmd_q[30:0]};
    assign wr_data = sh_nxt;
    assign wr_en   = act && (ph_q == PH_DATA) && last && cmd_q[31];
    assign dout    = (ph_q == PH_DATA) && out_q[31];

    // Frame sequencing: command, then data, then idle until deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            out_q <= '0;
            cmd_q <= '0;
            cnt_q <= '0;
            ph_q  <= PH_CMD;
        end else if (cs_n) begin
            cnt_q <= '0;
            ph_q  <= PH_CMD;
        end else if (bit_vld) begin
            unique case (ph_q)
                PH_CMD: begin
                    sh_q  <= sh_nxt[30:0];
                    cnt_q <= cnt_q + 5'd1;
                    if (last) begin
                        cmd_q <= sh_nxt;
                        out_q <= rd_data;
                        ph_q  <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    sh_q  <= sh_nxt[30:0];
                    out_q <= {out_q[30:0], 1'b0};
                    cnt_q <= cnt_q + 5'd1;
                    if (last) ph_q <= PH_DONE;
                end
                default: ;
            endcase
        end
    end

    a_r11_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (ph_q == PH_CMD && cnt_q == 5'd0));
    a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ph_q == PH_DONE || ph_q == PH_CMD));

endmodule

// File: rtl/rtc_regfile.sv
// Register file: decodes sparse offsets, holds scratch SRAM, snapshot,
// timer sets, trim and control registers, and latches sticky event flags
// with write-one-to-clear where a same-cycle event wins.
// Assumes SRAM_WORDS <= 256; scratch contents are not reset (battery-held).
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int unsigned SRAM_WORDS = 16,
    parameter logic [7:0]  REV        = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          rd_addr,
    output logic [31:0]          rd_data,
    input  logic                 wr_en,
    input  logic [31:0]          wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [NUM_FLAGS-1:0] evt,
    input  logic [31:0]          cnt_val,
    output logic                 cnt_load
);
    localparam logic [31:0] SRAM_SPAN = 32'(SRAM_WORDS) << 8;
    localparam logic [31:0] TRIM_SPAN = 32'(NUM_TRIM) << 8;

    // Maps an offset to a register class and slot index.
    function automatic dec_t decode(input logic [31:0] a);
        dec_t        d;
        logic [31:0] ds;
        logic [31:0] dt;
        d.kind = SEL_NONE;
        d.idx  = '0;
        ds = a - OFF_SRAM;
        dt = a - OFF_TRIM;
        if (a == OFF_COUNT)      d.kind = SEL_COUNT;
        else if (a == OFF_SNAP)  d.kind = SEL_SNAP;
        else if (a == OFF_ONT)   d.kind = SEL_ONT;
        else if (a == OFF_OFFT)  d.kind = SEL_OFFT;
        else if (a == OFF_CTL0)  d.kind = SEL_CTL0;
        else if (a == OFF_CTL1)  d.kind = SEL_CTL1;
        else if (ds < SRAM_SPAN && ds[7:0] == 8'h00) begin
            d.kind = SEL_SRAM;
            d.idx  = ds[15:8];
        end else if (dt < TRIM_SPAN && dt[7:0] == 8'h00) begin
            d.kind = SEL_TRIM;
            d.idx  = dt[15:8];
        end
        return d;
    endfunction

    dec_t rdec;
    dec_t wdec;
    assign rdec = decode(rd_addr);
    assign wdec = decode(wr_addr);

    logic [31:0]          sram_q [SRAM_WORDS];
    logic [31:0]          trim_q [NUM_TRIM];
    logic [31:0]          ont_q, offt_q, ctl1_q, snap_q;
    logic [NUM_FLAGS-1:0] flg_q;
    logic [NUM_FLAGS-1:0] clr;
    logic [31:0]          ctl0_w;
    logic                 wr_ctl0;

    assign cnt_load = wr_en && (wdec.kind == SEL_COUNT);
    assign wr_ctl0  = wr_en && (wdec.kind == SEL_CTL0);

    // Scratch words: one write port per slot, no reset.
    for (genvar i = 0; i < SRAM_WORDS; i++) begin : g_sram
        always_ff @(posedge clk) begin
            if (wr_en && wdec.kind == SEL_SRAM && wdec.idx == 8'(i))
                sram_q[i] <= wr_data;
        end
    end

    // Trim registers: reset to the fixed pattern, writable afterwards.
    for (genvar j = 0; j < NUM_TRIM; j++) begin : g_trim
        always_ff @(posedge clk) begin
            if (!rst_n)
                trim_q[j] <= TRIM_INIT;
            else if (wr_en && wdec.kind == SEL_TRIM && wdec.idx == 8'(j))
                trim_q[j] <= wr_data;
        end
    end

    // Plain read/write registers: timer sets and control register 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ont_q  <= '0;
            offt_q <= '0;
            ctl1_q <= '0;
        end else if (wr_en) begin
            if (wdec.kind == SEL_ONT)  ont_q  <= wr_data;
            if (wdec.kind == SEL_OFFT) offt_q <= wr_data;
            if (wdec.kind == SEL_CTL1) ctl1_q <= wr_data;
        end
    end

    // Snapshot: copies the counter on a power-on event, ignores writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 snap_q <= '0;
        else if (evt[EV_PON_TMR] || evt[EV_PON_SYS]) snap_q <= cnt_val;
    end

    // Sticky flags: event sets, write-one clears, event beats clear.
    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        localparam int unsigned FB = flag_bit(k);
        assign clr[k] = wr_ctl0 && wr_data[FB];
        always_ff @(posedge clk) begin
            if (!rst_n) flg_q[k] <= 1'b0;
            else        flg_q[k] <= evt[k] | (flg_q[k] & ~clr[k]);
        end

        a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt[k] |=> flg_q[k]);
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flg_q[k] && !clr[k]) |=> flg_q[k]);
    end

    // Control register 0 image: revision byte plus flags at their positions.
    always_comb begin
        ctl0_w = 32'(REV);
        for (int k = 0; k < NUM_FLAGS; k++) ctl0_w[flag_bit(k)] = flg_q[k];
    end

    // Read mux: undecoded offsets return zero.
    always_comb begin
        rd_data = '0;
        unique case (rdec.kind)
            SEL_COUNT: rd_data = cnt_val;
            SEL_SNAP:  rd_data = snap_q;
            SEL_ONT:   rd_data = ont_q;
            SEL_OFFT:  rd_data = offt_q;
            SEL_CTL0:  rd_data = ctl0_w;
            SEL_CTL1:  rd_data = ctl1_q;
            SEL_SRAM:
                for (int i = 0; i < SRAM_WORDS; i++)
                    if (rdec.idx == 8'(i)) rd_data = sram_q[i];
            SEL_TRIM:
                for (int j = 0; j < NUM_TRIM; j++)
                    if (rdec.idx == 8'(j)) rd_data = trim_q[j];
            default: rd_data = '0;
        endcase
    end

    a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt[EV_PON_TMR] || evt[EV_PON_SYS]) |=> $stable(snap_q));
    a_r10_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdec.kind == SEL_NONE) |=>
            ($stable(ont_q) && $stable(offt_q) && $stable(ctl1_q)));

endmodule

// File: rtl/rtc_serial_dev.sv
// Top: serial-bus RTC slave. Connects the frame engine, the seconds counter
// and the register file. Assumes all inputs are synchronous to clk.
module rtc_serial_dev
    import rtc_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 100_000_000,
    parameter int unsigned SRAM_WORDS = 16,
    parameter logic [7:0]  REV        = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 bit_vld,
    input  logic                 din,
    output logic                 dout,
    input  logic [NUM_FLAGS-1:0] evt
);
    logic [31:0] rd_addr, rd_data, wr_addr, wr_data, cnt_val;
    logic        wr_en, cnt_load;

    rtc_serial_if u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .bit_vld (bit_vld),
        .din     (din),
        .dout    (dout),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    rtc_seconds #(.TICK_DIV(TICK_DIV)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wr_data),
        .count    (cnt_val)
    );

    rtc_regfile #(.SRAM_WORDS(SRAM_WORDS), .REV(REV)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .evt      (evt),
        .cnt_val  (cnt_val),
        .cnt_load (cnt_load)
    );

endmodule

// File: tb/test_rtc_serial_dev.sv
module test_rtc_serial_dev;
    localparam int unsigned DIV = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       bit_vld = 1'b0;
    logic       din = 1'b0;
    logic       dout;
    logic [7:0] evt = 8'h00;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rtc_serial_dev #(.TICK_DIV(DIV), .SRAM_WORDS(16), .REV(8'h01)) i_rtc_serial_dev (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_vld(bit_vld),
        .din(din), .dout(dout), .evt(evt)
    );

    // Table: write the value, read it back, expect the given word.
    localparam int NV = 9;
    localparam logic [31:0] VA [NV] = '{
        32'h2000_0100,  // R3 slot 0
        32'h2000_1000,  // R3 slot 15
        32'h2000_0800,  // R3 slot 7
        32'h2100_0000,  // R5 ON set
        32'h2100_0100,  // R5 OFF set
        32'h2100_0500,  // R6 trim 1
        32'h2100_0D00,  // R9 control 1
        32'h2000_0180,  // R10 hole between slots
        32'h2100_0300   // R10 hole in control space
    };
    localparam logic [31:0] VD [NV] = '{
        32'hA5A5_0001, 32'hDEAD_BEEF, 32'h1357_2468, 32'h00C0_FFEE,
        32'h7777_AAAA, 32'h1234_5678, 32'hCAFE_F00D, 32'hFFFF_FFFF,
        32'h1111_1111
    };
    localparam logic [31:0] VE [NV] = '{
        32'hA5A5_0001, 32'hDEAD_BEEF, 32'h1357_2468, 32'h00C0_FFEE,
        32'h7777_AAAA, 32'h1234_5678, 32'hCAFE_F00D, 32'h0000_0000,
        32'h0000_0000
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One frame; nbits < 64 aborts early; evl is driven on the last data bit.
    task automatic xact(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, input int nbits, input logic [7:0] evl);
        logic [63:0] fr;
        fr = {wr, addr[30:0], wd};
        rd = '0;
        @(negedge clk);
        cs_n = 1'b0;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            if (b >= 32) rd = {rd[30:0], dout};
            din = fr[63-b];
            bit_vld = 1'b1;
            if (b == 63) evt = evl;
            @(posedge clk);
            #1;
            bit_vld = 1'b0;
            evt = 8'h00;
        end
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr32(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] unused;
        xact(1'b1, a, d, unused, 64, 8'h00);
    endtask

    task automatic rd32(input logic [31:0] a, output logic [31:0] d);
        xact(1'b0, a, 32'h0, d, 64, 8'h00);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] dummy;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state (counter read well inside the first second)
        rd32(32'h2000_0000, r); check("R12 counter", r, 32'h0);
        rd32(32'h2040_0000, r); check("R12 snapshot", r, 32'h0);
        rd32(32'h2100_0000, r); check("R12 ON set", r, 32'h0);
        rd32(32'h2100_0D00, r); check("R12 control1", r, 32'h0);
        rd32(32'h2100_0C00, r); check("R12 R7 control0", r, 32'h0000_0001);
        rd32(32'h2100_0400, r); check("R6 trim0 reset", r, 32'h0303_0303);
        rd32(32'h2100_0700, r); check("R6 trim3 reset", r, 32'h0303_0303);

        // R1 R3 R5 R6 R9 R10: table walk, then read all back once more
        for (int v = 0; v < NV; v++) begin
            wr32(VA[v], VD[v]);
            rd32(VA[v], r);
            check("R1 R3 R5 R6 R9 R10 table", r, VE[v]);
        end
        for (int v = 0; v < NV; v++) begin
            rd32(VA[v], r);
            check("R3 R10 table reread", r, VE[v]);
        end

        // R2 load, R4 snapshot on power-on events
        wr32(32'h2000_0000, 32'd500);
        rd32(32'h2000_0000, r); check("R2 load", r, 32'd500);
        @(negedge clk); evt = 8'hFF;
        @(negedge clk); evt = 8'h00;
        rd32(32'h2040_0000, r); check("R4 capture", r, 32'd500);
        wr32(32'h2040_0000, 32'h0000_1234);
        rd32(32'h2040_0000, r); check("R4 write ignored", r, 32'd500);

        // R7 flag positions and sticky behaviour
        rd32(32'h2100_0C00, r); check("R7 flags set", r, 32'h0703_0B01);
        rd32(32'h2100_0C00, r); check("R7 flags sticky", r, 32'h0703_0B01);
        // R8 write-one-to-clear; zeros keep flags; revision byte untouched
        wr32(32'h2100_0C00, 32'h0100_02FE);
        rd32(32'h2100_0C00, r); check("R8 R7 w1c", r, 32'h0603_0901);
        // R8 event on the clear cycle wins (event 7 -> bit 26)
        xact(1'b1, 32'h2100_0C00, 32'h0400_0000, dummy, 64, 8'h80);
        rd32(32'h2100_0C00, r); check("R8 event wins", r, 32'h0603_0901);
        wr32(32'h2100_0C00, 32'hFFFF_FFFF);
        rd32(32'h2100_0C00, r); check("R8 clear all", r, 32'h0000_0001);

        // R11 abort mid data word, then mid command word
        xact(1'b1, 32'h2100_0D00, 32'h0000_0000, dummy, 48, 8'h00);
        rd32(32'h2100_0D00, r); check("R11 abort data", r, 32'hCAFE_F00D);
        xact(1'b1, 32'h2100_0000, 32'h0, dummy, 10, 8'h00);
        rd32(32'h2100_0000, r); check("R11 abort cmd", r, 32'h00C0_FFEE);

        // R2 restart: an old prescaler phase would tick between load and read
        wr32(32'h2000_0000, 32'd1000);
        idle(900);
        wr32(32'h2000_0000, 32'd2000);
        idle(60);
        rd32(32'h2000_0000, r); check("R2 prescaler restart", r, 32'd2000);
        idle(1000);
        rd32(32'h2000_0000, r); check("R2 one tick", r, 32'd2001);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule